// File: doc/BRIEF.md
# Block-Copy Load Replay Tracker

This block sits beside the load/store queue of an out-of-order core. While a block-copy (memory move) instruction is in flight, the copy engine writes the destination one byte at a time and in no fixed order. Loads younger than the copy are allowed to execute early, before the copy has finished. Each such load is recorded in a small table, together with its tag and the physical byte range it read. The block then compares every byte written by the copy against all recorded loads. When a write lands inside a recorded load's range, the block asks for that load to be replayed so that it reads the new data.

While the copy is active, the block also holds back younger stores, so that none of them can become visible before the copy's own stores. Once the table is full, it stalls further younger loads. When the copy ends, entries that no longer matter are dropped. A pipeline flush drops everything at once.

Replay requests leave the block as one-cycle pulses that carry the load tag. A single byte write can match several loads. In that case the block reports them one per cycle, starting with the lowest table slot.

Top module: `mm_replay_tracker`

## Requirements
- R1: After reset, `rp_valid`, `ld_stall` and `st_hold` are all 0.
- R2: `st_hold` goes to 1 in the cycle after `mv_start` is sampled. It stays at 1 until the edge that samples `mv_end` or `flush`, and it is 0 after that edge.
- R3: A load allocation sampled while no copy is active is ignored, so a later copy write into that load's range raises no replay.
- R4: `ld_size` encodes the load length: 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes and 3 means 8 bytes. A write to address A matches a load when base <= A < base + length. Writes at base-1 and at base+length do not match.
- R5: A matching copy write sampled at edge E makes `rp_valid` equal 1 with `rp_tag` equal to the load's tag in the cycle after E, provided that no other replay is waiting. Each request lasts exactly one cycle.
- R6: Within one copy, a recorded load is replayed at most once. Later matching writes to it raise nothing.
- R7: When one write matches several loads, the loads are reported in consecutive cycles, lowest table slot first. Allocations fill the lowest free slot.
- R8: `ld_stall` is 1 while a copy is active and all 8 slots are valid. An allocation sampled while `ld_stall` is 1 is ignored.
- R9: `mv_end` drops every recorded load that has no replay waiting. A replay that is already waiting, including one raised by a write in the same cycle as `mv_end`, is still reported.
- R10: `flush` drops every recorded load and every waiting replay. It also ends the copy, and no replay is reported in the cycle after the flush.
- R11: When `ld_retire` is sampled with a recorded tag, that load is removed. It raises no later replay and frees its slot.
- R12: A load allocated in the same cycle as a copy write is compared against that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mv_start | input | 1 | Copy operation begins storing |
| mv_end | input | 1 | Copy operation has completed |
| flush | input | 1 | Pipeline flush; clears all state |
| st_valid | input | 1 | A copy byte write is presented |
| st_addr | input | ADDR_W | Physical byte address of the copy write |
| ld_alloc | input | 1 | A younger load executed and should be recorded |
| ld_tag | input | TAG_W | Tag of the allocating load |
| ld_addr | input | ADDR_W | Physical base address of the allocating load |
| ld_size | input | 2 | Length code of the allocating load (R4) |
| ld_retire | input | 1 | A load leaves the tracker |
| ld_retire_tag | input | TAG_W | Tag of the leaving load |
| rp_valid | output | 1 | Replay request pulse |
| rp_tag | output | TAG_W | Tag of the load to replay |
| ld_stall | output | 1 | Table full; stall younger loads |
| st_hold | output | 1 | Copy active; hold younger stores |

## Verification
The hardest situation to reach is a replay that is still waiting when the copy ends or when a flush arrives. Reaching it needs one byte write that matches two loads at once, so that the second match has to wait a cycle. That same write, or the cycle right after it, must coincide with `mv_end` or `flush`. The bench creates this by recording two loads whose ranges cover the same byte. It then issues the write together with `mv_end`, and in a second case follows the write at once with `flush`. The scoreboard checks that the waiting replay is reported after `mv_end` and dropped after `flush`.

// File: rtl/mrt_pkg.sv
package mrt_pkg;

    typedef enum logic [1:0] {
        SZ_B1 = 2'd0,
        SZ_B2 = 2'd1,
        SZ_B4 = 2'd2,
        SZ_B8 = 2'd3
    } ld_size_e;

    // Byte length for a size code (R4)
    function automatic logic [3:0] size_bytes(input ld_size_e sz);
        return 4'd1 << sz;
    endfunction

endpackage

// File: rtl/mrt_overlap.sv
module mrt_overlap
    import mrt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base,
    input  ld_size_e          size,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int EXT_W = ADDR_W + 1;

    logic [EXT_W-1:0] lo_w;
    logic [EXT_W-1:0] hi_w;
    logic [EXT_W-1:0] a_w;

    always_comb begin
        lo_w = {1'b0, base};
        hi_w = lo_w + EXT_W'(size_bytes(size));
        a_w  = {1'b0, addr};
        hit  = (a_w >= lo_w) && (a_w < hi_w);
    end

endmodule

// File: rtl/mrt_lowpick.sv
module mrt_lowpick #(
    parameter int N = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     gnt,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    always_comb begin
        gnt = '0;
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt = '0;
                gnt[i] = 1'b1;
                idx = IDX_W'(i);
                any = 1'b1;
            end
        end
    end

endmodule

// File: rtl/mm_replay_tracker.sv
module mm_replay_tracker
    import mrt_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 6,
    parameter int ADDR_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mv_start,
    input  logic              mv_end,
    input  logic              flush,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic              ld_alloc,
    input  logic [TAG_W-1:0]  ld_tag,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [1:0]        ld_size,
    input  logic              ld_retire,
    input  logic [TAG_W-1:0]  ld_retire_tag,
    output logic              rp_valid,
    output logic [TAG_W-1:0]  rp_tag,
    output logic              ld_stall,
    output logic              st_hold
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic                          active;
        logic [ENTRIES-1:0]            vld;
        logic [ENTRIES-1:0]            pend;
        logic [ENTRIES-1:0][TAG_W-1:0] tag;
        logic [ENTRIES-1:0][ADDR_W-1:0] base;
        logic [ENTRIES-1:0][1:0]       size;
        logic                          rp_v;
        logic [TAG_W-1:0]              rp_t;
    } state_t;

    state_t state_d;
    state_t state_q;

    // ---------------- comparison against the copy write ----------------
    logic [ENTRIES-1:0] ent_hit;
    logic               new_hit;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        mrt_overlap #(.ADDR_W(ADDR_W)) u_cmp (
            .base (state_q.base[g]),
            .size (ld_size_e'(state_q.size[g])),
            .addr (st_addr),
            .hit  (ent_hit[g])
        );
    end

    mrt_overlap #(.ADDR_W(ADDR_W)) u_cmp_new (
        .base (ld_addr),
        .size (ld_size_e'(ld_size)),
        .addr (st_addr),
        .hit  (new_hit)
    );

    // ---------------- free slot selection ----------------
    logic [ENTRIES-1:0] free_gnt;
    logic [IDX_W-1:0]   free_idx;
    logic               free_any;

    mrt_lowpick #(.N(ENTRIES)) u_free (
        .req (~state_q.vld),
        .gnt (free_gnt),
        .idx (free_idx),
        .any (free_any)
    );

    // ---------------- stage A: table after retire, alloc and hits ----------------
    logic                          store_ok;
    logic                          accept_ld;
    logic [ENTRIES-1:0]            ret_match;
    logic [ENTRIES-1:0]            vld_a;
    logic [ENTRIES-1:0]            pend_a;
    logic [ENTRIES-1:0][TAG_W-1:0] tag_a;
    logic [ENTRIES-1:0][ADDR_W-1:0] base_a;
    logic [ENTRIES-1:0][1:0]       size_a;

    always_comb begin
        store_ok  = st_valid && state_q.active;
        accept_ld = ld_alloc && state_q.active && free_any;
        for (int i = 0; i < ENTRIES; i++) begin
            ret_match[i] = ld_retire && state_q.vld[i]
                           && (state_q.tag[i] == ld_retire_tag);
        end
        vld_a  = state_q.vld & ~ret_match;
        pend_a = state_q.pend & vld_a;
        if (store_ok) begin
            pend_a = pend_a | (ent_hit & vld_a);
        end
        tag_a  = state_q.tag;
        base_a = state_q.base;
        size_a = state_q.size;
        if (accept_ld) begin
            vld_a[free_idx]  = 1'b1;
            pend_a[free_idx] = store_ok && new_hit;
            tag_a[free_idx]  = ld_tag;
            base_a[free_idx] = ld_addr;
            size_a[free_idx] = ld_size;
        end
    end

    // ---------------- replay selection ----------------
    logic [ENTRIES-1:0] rp_gnt;
    logic [IDX_W-1:0]   rp_idx;
    logic               rp_any;

    mrt_lowpick #(.N(ENTRIES)) u_rp (
        .req (pend_a),
        .gnt (rp_gnt),
        .idx (rp_idx),
        .any (rp_any)
    );

    // ---------------- next state ----------------
    always_comb begin
        state_d      = state_q;
        state_d.tag  = tag_a;
        state_d.base = base_a;
        state_d.size = size_a;
        state_d.vld  = vld_a & ~rp_gnt;
        state_d.pend = pend_a & ~rp_gnt;
        state_d.rp_v = rp_any;
        state_d.rp_t = rp_any ? tag_a[rp_idx] : '0;
        if (mv_end) begin
            state_d.active = 1'b0;
            state_d.vld    = state_d.vld & state_d.pend;
        end
        if (mv_start) begin
            state_d.active = 1'b1;
        end
        if (flush) begin
            state_d.active = 1'b0;
            state_d.vld    = '0;
            state_d.pend   = '0;
            state_d.rp_v   = 1'b0;
            state_d.rp_t   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rp_valid = state_q.rp_v;
    assign rp_tag   = state_q.rp_t;
    assign st_hold  = state_q.active;
    assign ld_stall = state_q.active && (&state_q.vld);

    // ---------------- assertions ----------------
    a_r2_start_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_start && !flush) |=> st_hold);

    a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!st_hold && !rp_valid && (state_q.vld == '0)));

    a_r9_end_keeps_pending_only: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_end && !mv_start && !flush) |=> ((state_q.vld & ~state_q.pend) == '0));

    a_r5_replay_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rp_valid |-> $past(st_valid || (|state_q.pend)));

    a_r6_pend_within_valid: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q.pend & ~state_q.vld) == '0));

    a_r7_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rp_gnt));

    a_r7_grant_is_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        (rp_gnt != '0) |-> (((pend_a & (rp_gnt - 1'b1)) == '0) && ((rp_gnt & pend_a) != '0)));

    a_r8_stall_only_active: assert property (@(posedge clk) disable iff (!rst_n)
        ld_stall |-> st_hold);

endmodule

// File: tb/mm_replay_tracker_tb.sv
module mm_replay_tracker_tb;
    localparam int TAG_W  = 6;
    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mv_start = 1'b0, mv_end = 1'b0, flush = 1'b0;
    logic              st_valid = 1'b0;
    logic [ADDR_W-1:0] st_addr = '0;
    logic              ld_alloc = 1'b0;
    logic [TAG_W-1:0]  ld_tag = '0;
    logic [ADDR_W-1:0] ld_addr = '0;
    logic [1:0]        ld_size = '0;
    logic              ld_retire = 1'b0;
    logic [TAG_W-1:0]  ld_retire_tag = '0;
    logic              rp_valid;
    logic [TAG_W-1:0]  rp_tag;
    logic              ld_stall;
    logic              st_hold;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int    exp_tag[$];
    string exp_req[$];

    always #10 clk = ~clk;

    mm_replay_tracker #(.ENTRIES(8), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .mv_start(mv_start), .mv_end(mv_end), .flush(flush),
        .st_valid(st_valid), .st_addr(st_addr), .ld_alloc(ld_alloc), .ld_tag(ld_tag),
        .ld_addr(ld_addr), .ld_size(ld_size), .ld_retire(ld_retire),
        .ld_retire_tag(ld_retire_tag), .rp_valid(rp_valid), .rp_tag(rp_tag),
        .ld_stall(ld_stall), .st_hold(st_hold)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: every replay pulse must match the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && rp_valid) begin
            if (exp_tag.size() == 0) begin
                chk(1'b0, "R6 unexpected replay", int'(rp_tag), -1);
            end else begin
                string r;
                int t;
                t = exp_tag.pop_front();
                r = exp_req.pop_front();
                chk(int'(rp_tag) == t, r, int'(rp_tag), t);
            end
        end
    end

    task automatic expect_rp(input int t, input string req);
        exp_tag.push_back(t);
        exp_req.push_back(req);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic do_alloc(input int t, input int a, input int s);
        ld_alloc = 1'b1; ld_tag = TAG_W'(t); ld_addr = ADDR_W'(a); ld_size = 2'(s);
        tick();
        ld_alloc = 1'b0;
    endtask

    task automatic do_store(input int a);
        st_valid = 1'b1; st_addr = ADDR_W'(a);
        tick();
        st_valid = 1'b0;
    endtask

    task automatic do_retire(input int t);
        ld_retire = 1'b1; ld_retire_tag = TAG_W'(t);
        tick();
        ld_retire = 1'b0;
    endtask

    task automatic pulse_start();
        mv_start = 1'b1; tick(); mv_start = 1'b0;
    endtask

    task automatic pulse_end();
        mv_end = 1'b1; tick(); mv_end = 1'b0;
    endtask

    task automatic drain(input string req);
        idle(4);
        chk(exp_tag.size() == 0, req, exp_tag.size(), 0);
    endtask

    initial begin
        #5;
        chk(rp_valid == 1'b0, "R1 rp_valid", int'(rp_valid), 0);
        chk(ld_stall == 1'b0, "R1 ld_stall", int'(ld_stall), 0);
        chk(st_hold == 1'b0, "R1 st_hold", int'(st_hold), 0);
        idle(2);
        rst_n = 1'b1;
        idle(1);

        // R3: allocation while idle is ignored
        do_alloc(5, 'h100, 3);
        pulse_start();
        chk(st_hold == 1'b1, "R2 hold after start", int'(st_hold), 1);
        do_store('h100);
        drain("R3 idle alloc ignored");

        // R4/R5/R6: range edges, latency, single replay
        do_alloc(1, 'h200, 2);
        do_store('h1FF);
        do_store('h204);
        drain("R4 outside range");
        expect_rp(1, "R4 last byte of 4-byte load");
        do_store('h203);
        chk(rp_valid == 1'b1 && rp_tag == 6'd1, "R5 replay next cycle", int'(rp_valid), 1);
        tick();
        chk(rp_valid == 1'b0, "R5 single-cycle pulse", int'(rp_valid), 0);
        do_store('h200);
        drain("R6 no second replay");

        do_alloc(2, 'h300, 0);
        do_store('h301);
        expect_rp(2, "R4 one-byte load");
        do_store('h300);
        do_alloc(3, 'h408, 3);
        expect_rp(3, "R4 eight-byte load top byte");
        do_store('h40F);
        drain("R4 sizes");

        pulse_end();
        chk(st_hold == 1'b0, "R2 release on end", int'(st_hold), 0);

        // R7: multiple matches, lowest slot first
        pulse_start();
        do_alloc(10, 'h500, 3);
        do_alloc(11, 'h4F8, 3);
        do_alloc(12, 'h501, 0);
        do_alloc(13, 'h500, 1);
        expect_rp(10, "R7 first of three");
        expect_rp(12, "R7 second of three");
        expect_rp(13, "R7 third of three");
        do_store('h501);
        chk(rp_valid && rp_tag == 6'd10, "R7 cycle 1", int'(rp_tag), 10);
        tick();
        chk(rp_valid && rp_tag == 6'd12, "R7 cycle 2", int'(rp_tag), 12);
        tick();
        chk(rp_valid && rp_tag == 6'd13, "R7 cycle 3", int'(rp_tag), 13);
        drain("R7 order");
        pulse_end();

        // R8: full table
        pulse_start();
        for (int i = 0; i < 8; i++) do_alloc(20 + i, 'h1000 + 16 * i, 0);
        chk(ld_stall == 1'b1, "R8 stall when full", int'(ld_stall), 1);
        do_alloc(40, 'h2000, 0);
        do_store('h2000);
        drain("R8 alloc while full ignored");

        // R11: retire removes entry
        do_retire(21);
        chk(ld_stall == 1'b0, "R11 slot freed", int'(ld_stall), 0);
        do_store('h1010);
        drain("R11 retired load not replayed");

        // R12: same-cycle alloc and store
        ld_alloc = 1'b1; ld_tag = 6'd41; ld_addr = 'h3000; ld_size = 2'd0;
        st_valid = 1'b1; st_addr = 'h3000;
        expect_rp(41, "R12 same-cycle alloc checked");
        tick();
        ld_alloc = 1'b0; st_valid = 1'b0;
        drain("R12");

        // R9: waiting replay survives end; others dropped
        do_alloc(42, 'h1040, 0);
        expect_rp(42, "R9 replay at end, slot 1");
        expect_rp(24, "R9 waiting replay after end");
        st_valid = 1'b1; st_addr = 'h1040; mv_end = 1'b1;
        tick();
        st_valid = 1'b0; mv_end = 1'b0;
        chk(st_hold == 1'b0, "R2 release with store", int'(st_hold), 0);
        drain("R9 pending drained");
        pulse_start();
        do_store('h1000);
        drain("R9 non-pending dropped");

        // R10: flush drops waiting replay
        do_alloc(50, 'h6000, 3);
        do_alloc(51, 'h6000, 3);
        expect_rp(50, "R10 replay before flush");
        do_store('h6000);
        flush = 1'b1;
        tick();
        flush = 1'b0;
        chk(rp_valid == 1'b0, "R10 no replay after flush", int'(rp_valid), 0);
        chk(st_hold == 1'b0, "R10 flush ends copy", int'(st_hold), 0);
        drain("R10 pending dropped");
        pulse_start();
        do_store('h6000);
        drain("R10 entries dropped");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule